// File: doc/BRIEF.md
# Bipolar Line Encoder with Zero-Substitution Codes

This block turns a transmit bit stream into the pair of pulse enables that drive a bipolar line driver. In single-rail mode each NRZ bit is encoded with alternate mark inversion. Two zero-substitution codes can be selected instead: a four-zero code and an eight-zero code. Both codes replace long runs of zeros with patterns that contain deliberate bipolar violations, so that the far end keeps enough transitions to recover the clock. In dual-rail mode the two rail inputs already carry encoded data. They are mapped to pulses through a fixed table and bypass the substitution and polarity logic.

The block runs on a fast system clock. It watches the slower transmit bit clock as a data input. Each bit is sampled on the rising or the falling edge of that clock, as chosen by a select input. A bit entering the block reaches the outputs exactly eight sampling edges later, in every mode and every code. The eight-bit window doubles as the lookahead that the eight-zero code needs, and the output timing stays the same when the code changes. The outputs are registered and change only on sampling edges, so each pulse enable lasts one full bit period. The two enables are meant for a downstream pulse shaper.

Top module: `line_coder`

## Requirements
- R1: While `rst` is high and after it is released, both pulse outputs are low. The first mark encoded after reset is a positive pulse. The eight outputs that follow reset, before any sampled bit has come through, are spaces.
- R2: The inputs are sampled only on the transmit clock edge picked by `fall_edge`: 0 picks the rising edge, 1 picks the falling edge. Data present on the other edge has no effect. The outputs change only at a sampling edge.
- R3: With `code_sel` = 00 or 11 (alternate mark inversion), each 1 bit gives a pulse whose polarity is opposite to the previous pulse, and each 0 bit gives a space.
- R4: With `code_sel` = 01 (four-zero code), each run of four zeros is replaced as follows. If the count of pulses since the last violation (or since reset) is odd, the run becomes 0,0,0,V. If the count is even, the run becomes B,0,0,V. B is a normal alternating pulse. V has the same polarity as the pulse before it. A violation resets the count.
- R5: With `code_sel` = 10 (eight-zero code), each run of eight zeros becomes 0,0,0,V,B,0,V,B in time order. V repeats the polarity of the preceding pulse and B alternates.
- R6: With `dual_rail` = 1, the rail pair (`din_p`,`din_n`) maps as follows. 00 and 11 give a space. 01 gives a positive pulse. 10 gives a negative pulse.
- R7: With `dual_rail` = 0, `din_n` has no effect on the outputs.
- R8: `pulse_pos` and `pulse_neg` are never high together.
- R9: A bit sampled on edge k appears at the outputs after sampling edge k+8. This holds for every code and for dual-rail mode.
- R10: The polarity memory is shared by data marks and substituted pulses. It changes only at a sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk | input | 1 | Transmit bit clock, sampled as data |
| fall_edge | input | 1 | 1: sample on the falling edge of tx_clk; 0: sample on the rising edge |
| dual_rail | input | 1 | 1: pre-encoded rail inputs; 0: NRZ data on din_p |
| code_sel | input | 2 | 00/11 alternate mark inversion, 01 four-zero code, 10 eight-zero code |
| din_p | input | 1 | NRZ data, or the positive rail in dual-rail mode |
| din_n | input | 1 | Negative rail in dual-rail mode; ignored otherwise |
| pulse_pos | output | 1 | Positive pulse enable |
| pulse_neg | output | 1 | Negative pulse enable |

## Verification
The bench drives zero runs of 4, 7, 8, 9 and 16 bits, framed by marks, through every code on both sampling edges, and compares each output against an offline encoding of the same stream.

Each corner case targets a specific fault:
- Runs of 16 zeros require both the 0,0,0,V and B,0,0,V forms of the four-zero code. An encoder that ignores the pulse-count parity would give two violations of the same polarity.
- Zeros fed in after the last data bit finish runs that began earlier. A design that decided substitutions too late would fail on these.
- Between the two clock edges, the data is replaced by its complement, and `din_n` toggles on its own in single-rail mode. Sampling on the wrong edge, or leaking `din_n` into the encoder, would corrupt the output stream.
- Checking the edge on which the first mark appears, and its polarity, catches a pipeline of the wrong depth and a wrong polarity reset state.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  // symbol kinds carried down the lookahead pipeline
  typedef enum logic [2:0] {
    K_RAIL = 3'd0,  // pre-encoded rail pair, also the reset filler
    K_DATA = 3'd1,  // plain NRZ bit
    K_V    = 3'd2,  // bipolar violation
    K_B    = 3'd3,  // alternating substitution pulse
    K_HB   = 3'd4   // four-zero code lead: pulse or space by parity
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  a;   // NRZ bit or positive rail
    logic  b;   // negative rail
  } sym_t;

  localparam logic [1:0] CODE_AMI  = 2'b00;
  localparam logic [1:0] CODE_HDB  = 2'b01;
  localparam logic [1:0] CODE_B8   = 2'b10;
endpackage

// File: rtl/lc_edge_pick.sv
`timescale 1ns/1ps
module lc_edge_pick (
  input  logic clk,
  input  logic rst,
  input  logic tx_clk,
  input  logic fall_edge,
  output logic stb
);
  logic tx_q;

  always_ff @(posedge clk) begin
    if (rst) tx_q <= 1'b0;
    else     tx_q <= tx_clk;
  end

  assign stb = fall_edge ? (tx_q & ~tx_clk) : (~tx_q & tx_clk);
endmodule

// File: rtl/lc_sub_pipe.sv
`timescale 1ns/1ps
module lc_sub_pipe
  import lc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb,
  input  logic       dual_rail,
  input  logic [1:0] code_sel,
  input  logic       din_p,
  input  logic       din_n,
  output sym_t       tail
);
  localparam int HDB_LEN = 4;
  localparam int B8_LEN  = 8;
  // eight-zero pattern positions counted from the newest entry
  localparam int B8_B0 = 0;
  localparam int B8_V0 = 1;
  localparam int B8_B1 = 3;
  localparam int B8_V1 = 4;

  sym_t st  [DEPTH];
  sym_t nst [DEPTH];
  sym_t nxt;
  logic [DEPTH-1:0] z;
  logic hdb_hit, b8_hit;

  // untagged zero flags per stage
  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_zero
      assign z[gi] = (st[gi].kind == K_DATA) && !st[gi].a;
    end
  endgenerate

  always_comb begin
    if (dual_rail) nxt = '{kind: K_RAIL, a: din_p, b: din_n};
    else           nxt = '{kind: K_DATA, a: din_p, b: 1'b0};
  end

  assign hdb_hit = !dual_rail && (code_sel == CODE_HDB) && !din_p && (&z[HDB_LEN-2:0]);
  assign b8_hit  = !dual_rail && (code_sel == CODE_B8)  && !din_p && (&z[B8_LEN-2:0]);

  always_comb begin
    nst[0] = nxt;
    for (int i = 1; i < DEPTH; i++) nst[i] = st[i-1];
    if (hdb_hit) begin
      nst[0].kind         = K_V;
      nst[HDB_LEN-1].kind = K_HB;
    end
    if (b8_hit) begin
      nst[B8_B0].kind = K_B;
      nst[B8_V0].kind = K_V;
      nst[B8_B1].kind = K_B;
      nst[B8_V1].kind = K_V;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)      st[i] <= '{kind: K_RAIL, a: 1'b0, b: 1'b0};
      else if (stb) st[i] <= nst[i];
    end
  end

  assign tail = st[DEPTH-1];
endmodule

// File: rtl/lc_polarizer.sv
`timescale 1ns/1ps
module lc_polarizer
  import lc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  sym_t sym,
  output logic pos,
  output logic neg,
  output logic last_neg
);
  logic odd;  // parity of pulses since the last violation

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= 1'b0;
      neg      <= 1'b0;
      last_neg <= 1'b1;
      odd      <= 1'b0;
    end else if (stb) begin
      pos <= 1'b0;
      neg <= 1'b0;
      case (sym.kind)
        K_RAIL: begin
          pos <= !sym.a && sym.b;
          neg <= sym.a && !sym.b;
        end
        K_V: begin
          pos <= !last_neg;
          neg <= last_neg;
          odd <= 1'b0;
        end
        K_DATA, K_B, K_HB: begin
          if ((sym.kind == K_B) || (sym.kind == K_DATA && sym.a) ||
              (sym.kind == K_HB && !odd)) begin
            pos      <= last_neg;
            neg      <= !last_neg;
            last_neg <= !last_neg;
            odd      <= !odd;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/line_coder.sv
`timescale 1ns/1ps
module line_coder
  import lc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_clk,
  input  logic       fall_edge,
  input  logic       dual_rail,
  input  logic [1:0] code_sel,
  input  logic       din_p,
  input  logic       din_n,
  output logic       pulse_pos,
  output logic       pulse_neg
);
  logic bit_stb;
  logic pol_neg;
  sym_t tail;

  lc_edge_pick u_edge (
    .clk(clk), .rst(rst), .tx_clk(tx_clk), .fall_edge(fall_edge), .stb(bit_stb)
  );

  lc_sub_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk(clk), .rst(rst), .stb(bit_stb), .dual_rail(dual_rail),
    .code_sel(code_sel), .din_p(din_p), .din_n(din_n), .tail(tail)
  );

  lc_polarizer u_pol (
    .clk(clk), .rst(rst), .stb(bit_stb), .sym(tail),
    .pos(pulse_pos), .neg(pulse_neg), .last_neg(pol_neg)
  );
endmodule

// File: rtl/lc_checker.sv
`timescale 1ns/1ps
module lc_checker (
  input logic clk,
  input logic rst,
  input logic tx_clk,
  input logic pulse_pos,
  input logic pulse_neg,
  input logic stb,
  input logic last_neg
);
  // R8: never both pulse enables
  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(pulse_pos && pulse_neg));

  // R2: no tx_clk change seen means outputs hold
  assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (tx_clk == $past(tx_clk))) |=> $stable({pulse_pos, pulse_neg}));

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pulse_pos && !pulse_neg));

  // R10: polarity memory moves only on a sampling edge
  assert_pol_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(last_neg));
endmodule

bind line_coder lc_checker u_chk (
  .clk(clk), .rst(rst), .tx_clk(tx_clk), .pulse_pos(pulse_pos),
  .pulse_neg(pulse_neg), .stb(bit_stb), .last_neg(pol_neg)
);

// File: tb/test_line_coder.sv
`timescale 1ns/1ps
module test_line_coder;
  localparam int N = 96;
  localparam int L = N + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_clk = 1'b0;
  logic fall_edge = 1'b0;
  logic dual_rail = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic din_p = 1'b0;
  logic din_n = 1'b0;
  logic pulse_pos, pulse_neg;

  int checks = 0;
  int bad = 0;
  logic [15:0] seed = 16'hACE1;

  logic bits_p [L];
  logic bits_n [L];
  int   sym    [L];
  logic ep     [L];
  logic en     [L];
  logic op     [L];
  logic on     [L];

  always #2.5 clk = ~clk;

  line_coder i_line_coder (
    .clk(clk), .rst(rst), .tx_clk(tx_clk), .fall_edge(fall_edge),
    .dual_rail(dual_rail), .code_sel(code_sel), .din_p(din_p), .din_n(din_n),
    .pulse_pos(pulse_pos), .pulse_neg(pulse_neg)
  );

  function automatic logic lfsr_bit();
    seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
    return seed[0];
  endfunction

  task automatic check(input string tag, input int idx, input logic gp, input logic gn,
                       input logic xp, input logic xn);
    checks++;
    if (gp !== xp || gn !== xn) begin
      bad++;
      $display("FAIL %s idx %0d: got p=%b n=%b expected p=%b n=%b", tag, idx, gp, gn, xp, xn);
    end
  endtask

  task automatic do_reset(input logic fe, input logic dr, input logic [1:0] cs);
    rst = 1'b1; fall_edge = fe; dual_rail = dr; code_sel = cs;
    tx_clk = fe; din_p = 1'b0; din_n = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset", 0, pulse_pos, pulse_neg, 1'b0, 1'b0);
  endtask

  // one bit period: active edge, then complemented data across the inactive edge
  task automatic send(input logic p, input logic n, output logic gp, output logic gn);
    din_p = p; din_n = n;
    repeat (2) @(negedge clk);
    tx_clk = ~fall_edge;
    @(negedge clk);
    din_p = ~p; din_n = ~n;
    repeat (3) @(negedge clk);
    tx_clk = fall_edge;
    repeat (3) @(negedge clk);
    gp = pulse_pos; gn = pulse_neg;
  endtask

  task automatic build_single();
    for (int i = 0; i < L; i++) begin
      bits_p[i] = (i < N) ? lfsr_bit() : 1'b0;
      bits_n[i] = lfsr_bit();
    end
    for (int i = 10; i <= 13; i++) bits_p[i] = 1'b0;
    for (int i = 20; i <= 27; i++) bits_p[i] = 1'b0;
    for (int i = 35; i <= 43; i++) bits_p[i] = 1'b0;
    for (int i = 50; i <= 65; i++) bits_p[i] = 1'b0;
    for (int i = 70; i <= 76; i++) bits_p[i] = 1'b0;
    for (int i = 80; i <= 82; i++) bits_p[i] = 1'b0;
    bits_p[0] = 1'b1;
    bits_p[9] = 1'b1;  bits_p[14] = 1'b1; bits_p[19] = 1'b1; bits_p[28] = 1'b1;
    bits_p[34] = 1'b1; bits_p[44] = 1'b1; bits_p[49] = 1'b1; bits_p[66] = 1'b1;
    bits_p[69] = 1'b1; bits_p[77] = 1'b1; bits_p[79] = 1'b1; bits_p[83] = 1'b1;
  endtask

  // symbols: 0 space, 1 mark, 2 V, 3 B, 4 parity-dependent lead
  task automatic model_single(input logic [1:0] cs);
    int zr;
    logic lneg, odd;
    zr = 0;
    for (int i = 0; i < L; i++) begin
      if (bits_p[i]) begin sym[i] = 1; zr = 0; end
      else begin
        sym[i] = 0; zr++;
        if (cs == 2'b01 && zr == 4) begin sym[i-3] = 4; sym[i] = 2; zr = 0; end
        if (cs == 2'b10 && zr == 8) begin
          sym[i-4] = 2; sym[i-3] = 3; sym[i-1] = 2; sym[i] = 3; zr = 0;
        end
      end
    end
    lneg = 1'b1; odd = 1'b0;
    for (int i = 0; i < L; i++) begin
      ep[i] = 1'b0; en[i] = 1'b0;
      if (sym[i] == 2) begin
        ep[i] = !lneg; en[i] = lneg; odd = 1'b0;
      end else if (sym[i] == 1 || sym[i] == 3 || (sym[i] == 4 && !odd)) begin
        ep[i] = lneg; en[i] = !lneg; lneg = !lneg; odd = !odd;
      end
    end
  endtask

  task automatic run_single(input logic [1:0] cs, input logic fe, input string tag);
    logic gp, gn;
    build_single();
    model_single(cs);
    do_reset(fe, 1'b0, cs);
    for (int k = 0; k < L; k++) begin
      send(bits_p[k], bits_n[k], gp, gn);
      op[k] = gp; on[k] = gn;
      checks++;
      if (gp && gn) begin
        bad++;
        $display("FAIL R8 %s idx %0d: got p=%b n=%b expected not both", tag, k, gp, gn);
      end
      if (k < 8) check({tag, " R1 fill"}, k, gp, gn, 1'b0, 1'b0);
      else       check(tag, k, gp, gn, ep[k-8], en[k-8]);
    end
    // R9: first mark (bit 0) emerges after edge 8; R1: it is positive
    check({tag, " R9 latency"}, 7, op[7], on[7], 1'b0, 1'b0);
    check({tag, " R9 R1 first mark"}, 8, op[8], on[8], 1'b1, 1'b0);
  endtask

  task automatic run_dual(input logic fe, input string tag);
    logic gp, gn;
    for (int i = 0; i < L; i++) begin
      bits_p[i] = lfsr_bit(); bits_n[i] = lfsr_bit();
      ep[i] = !bits_p[i] && bits_n[i];
      en[i] = bits_p[i] && !bits_n[i];
    end
    do_reset(fe, 1'b1, 2'b10);
    for (int k = 0; k < L; k++) begin
      send(bits_p[k], bits_n[k], gp, gn);
      if (k < 8) check({tag, " R9 fill"}, k, gp, gn, 1'b0, 1'b0);
      else       check(tag, k, gp, gn, ep[k-8], en[k-8]);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    run_single(2'b00, 1'b0, "R3 R7 AMI rise");
    run_single(2'b00, 1'b1, "R3 R7 R2 AMI fall");
    run_single(2'b11, 1'b0, "R3 R7 code11");
    run_single(2'b01, 1'b0, "R4 R10 R7 four-zero rise");
    run_single(2'b01, 1'b1, "R4 R10 R2 four-zero fall");
    run_single(2'b10, 1'b0, "R5 R10 R7 eight-zero rise");
    run_single(2'b10, 1'b1, "R5 R10 R2 eight-zero fall");
    run_dual(1'b0, "R6 dual rise");
    run_dual(1'b1, "R6 R2 dual fall");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule